// File: doc/BRIEF.md
# Address Decoder with Write-Through Bank Registers

This block turns the 16-bit address of an 8-bit CPU bus into chip selects for the system's memories. Every address selects exactly one device: base RAM, ROM, a banked-RAM window or one of eight 32-byte I/O slots. Base RAM is the default target. It loses its select only when the address lands in the ROM range, the banked window or the I/O page, and that device takes the select instead. Reads are decoded whenever the address is valid. Write selects are only active while the bus phase input `phi2` is high.

The block also holds two bank-number registers that mirror zero-page RAM. A write to address 0 or address 1 goes to RAM as usual, because RAM stays selected for those addresses. The same write also loads the RAM bank register or the ROM bank register, so software can read the bank numbers back from RAM. The registers cannot be read from the bus. They drive the upper address lines of the banked RAM and the ROM, both of which sit in the upper half of the address map.

The registers are sampled in the system clock domain. A controller with three states follows the bus phase:

- `BUS_IDLE`: `phi2` is low.
- `BUS_READ`: `phi2` is high with `rw`=1.
- `BUS_WRITE`: `phi2` is high with `rw`=0.

The transitions are:

- IDLE to READ or IDLE to WRITE on a rising `phi2`, chosen by `rw`.
- READ to WRITE or WRITE to READ if `rw` changes while `phi2` is high.
- READ to IDLE on a falling `phi2`.
- WRITE to IDLE on a falling `phi2`. This is the commit transition, which loads the register using the address and data captured in the last clock cycle in which `phi2` was high.

Top module: `memdec_top`

## Requirements
- R1: When selects are enabled (`rw`=1, or `rw`=0 with `phi2`=1), exactly one of `ram_cs`, `io_cs`, `bram_cs`, `rom_cs` is 1. During a write with `phi2`=0, all four and `io_slot_sel` are 0.
- R2: Enabled decoding selects the ROM for $C000–$FFFF, banked RAM for $A000–$BFFF and I/O for $9F00–$9FFF. Every other address selects base RAM.
- R3: `io_slot_sel` is one-hot with the set bit at index addr[7:5] whenever `io_cs` is 1, and it is all zero whenever `io_cs` is 0.
- R4: A write bus phase to address $0000 loads `ram_bank` with the 8-bit data. The new value appears one clock edge after `phi2` is first sampled low, and it uses the data present in the last high-phase cycle.
- R5: A write bus phase to address $0001 loads `rom_bank` with data bits 4:0 at the same point in time as R4.
- R6: Addresses $0000 and $0001 keep `ram_cs` asserted for reads and writes. A read of either address never changes a bank register. After a write, a RAM read of that address returns the register's value.
- R7: Writes to any other address and read cycles leave both bank registers unchanged.
- R8: Reset (`rst_n`=0) clears `ram_bank` and `rom_bank` to 0.
- R9: A bank register changes only on the clock edge that follows a `phi2` high-to-low transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | Bus clock phase. A high phase is the data phase |
| addr | input | 16 | CPU address |
| data_in | input | 8 | CPU write data |
| rw | input | 1 | 1 = read, 0 = write |
| ram_cs | output | 1 | Base RAM select |
| rom_cs | output | 1 | ROM select |
| bram_cs | output | 1 | Banked-RAM window select |
| io_cs | output | 1 | I/O page select |
| io_slot_sel | output | 8 | One select per 32-byte I/O slot |
| ram_bank | output | 8 | RAM bank number (upper address of banked RAM) |
| rom_bank | output | 5 | ROM bank number (upper address of ROM) |

## Verification
The assertions check on every cycle:

- the selects are mutually exclusive and are gated during the low half of a write (R1);
- the ROM range and zero page map to the right device (R2, R6);
- the I/O slot selects are one-hot (R3);
- both bank registers are cleared after reset (R8);
- the bank registers hold between `phi2` falling edges (R9).

Other behaviour can only be shown by the bench's scenarios. These include which data value is captured and in which cycle, writes to other addresses leaving the registers unchanged, and reads of RAM returning the same value as the register after a write.

// File: rtl/memdec_pkg.sv
package memdec_pkg;

    typedef enum logic [1:0] {
        REG_RAM  = 2'd0,
        REG_IO   = 2'd1,
        REG_BRAM = 2'd2,
        REG_ROM  = 2'd3
    } region_t;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_state_t;

endpackage

// File: rtl/memdec_region.sv
module memdec_region
    import memdec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] IO_BASE   = 16'h9F00,
    parameter logic [ADDR_W-1:0] BRAM_BASE = 16'hA000,
    parameter logic [ADDR_W-1:0] ROM_BASE  = 16'hC000
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region
);

    // Priority goes from the top of the map downward; RAM is the default.
    always_comb begin
        if (addr >= ROM_BASE)
            region = REG_ROM;
        else if (addr >= BRAM_BASE)
            region = REG_BRAM;
        else if (addr >= IO_BASE)
            region = REG_IO;
        else
            region = REG_RAM;
    end

endmodule

// File: rtl/memdec_select.sv
module memdec_select
    import memdec_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int IO_SLOTS      = 8,
    parameter int IO_SLOT_SHIFT = 5,
    localparam int SLOT_IDX_W   = (IO_SLOTS > 1) ? $clog2(IO_SLOTS) : 1
) (
    input  region_t             region,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                enable,
    output logic                ram_cs,
    output logic                rom_cs,
    output logic                bram_cs,
    output logic                io_cs,
    output logic [IO_SLOTS-1:0] io_slot_sel
);

    logic [SLOT_IDX_W-1:0] slot_idx;

    assign slot_idx = addr[IO_SLOT_SHIFT +: SLOT_IDX_W];

    always_comb begin
        ram_cs  = 1'b0;
        rom_cs  = 1'b0;
        bram_cs = 1'b0;
        io_cs   = 1'b0;
        if (enable) begin
            unique case (region)
                REG_RAM:  ram_cs  = 1'b1;
                REG_IO:   io_cs   = 1'b1;
                REG_BRAM: bram_cs = 1'b1;
                REG_ROM:  rom_cs  = 1'b1;
                default:  ram_cs  = 1'b1;
            endcase
        end
    end

    for (genvar g = 0; g < IO_SLOTS; g++) begin : g_slot
        assign io_slot_sel[g] = io_cs && (slot_idx == SLOT_IDX_W'(g));
    end

endmodule

// File: rtl/memdec_bank_regs.sv
module memdec_bank_regs
    import memdec_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int RAM_BANK_W = 8,
    parameter int ROM_BANK_W = 5,
    parameter logic [ADDR_W-1:0] RAM_BANK_ADDR = 16'h0000,
    parameter logic [ADDR_W-1:0] ROM_BANK_ADDR = 16'h0001
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  phi2,
    input  logic                  rw,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     data_in,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic [ROM_BANK_W-1:0] rom_bank
);

    bus_state_t state_q, state_d;

    logic              hold_ram_hit;
    logic              hold_rom_hit;
    logic [DATA_W-1:0] hold_data;
    logic              commit;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= BUS_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:  if (phi2) state_d = rw ? BUS_READ : BUS_WRITE;
            BUS_READ:  if (!phi2) state_d = BUS_IDLE;
                       else if (!rw) state_d = BUS_WRITE;
            BUS_WRITE: if (!phi2) state_d = BUS_IDLE;
                       else if (rw) state_d = BUS_READ;
            default:   state_d = BUS_IDLE;
        endcase
    end

    // Outputs: a commit happens on the WRITE -> IDLE transition.
    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            BUS_WRITE: commit = !phi2;
            BUS_IDLE,
            BUS_READ:  commit = 1'b0;
            default:   commit = 1'b0;
        endcase
    end

    // Address and data from the latest high-phase write cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_ram_hit <= 1'b0;
            hold_rom_hit <= 1'b0;
            hold_data    <= '0;
        end else if (phi2 && !rw) begin
            hold_ram_hit <= (addr == RAM_BANK_ADDR);
            hold_rom_hit <= (addr == ROM_BANK_ADDR);
            hold_data    <= data_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_bank <= '0;
            rom_bank <= '0;
        end else if (commit) begin
            if (hold_ram_hit) ram_bank <= hold_data[RAM_BANK_W-1:0];
            if (hold_rom_hit) rom_bank <= hold_data[ROM_BANK_W-1:0];
        end
    end

endmodule

// File: rtl/memdec_top.sv
module memdec_top
    import memdec_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int RAM_BANK_W    = 8,
    parameter int ROM_BANK_W    = 5,
    parameter int IO_SLOTS      = 8,
    parameter int IO_SLOT_SHIFT = 5,
    parameter logic [ADDR_W-1:0] IO_BASE       = 16'h9F00,
    parameter logic [ADDR_W-1:0] BRAM_BASE     = 16'hA000,
    parameter logic [ADDR_W-1:0] ROM_BASE      = 16'hC000,
    parameter logic [ADDR_W-1:0] RAM_BANK_ADDR = 16'h0000,
    parameter logic [ADDR_W-1:0] ROM_BANK_ADDR = 16'h0001
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  phi2,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     data_in,
    input  logic                  rw,
    output logic                  ram_cs,
    output logic                  rom_cs,
    output logic                  bram_cs,
    output logic                  io_cs,
    output logic [IO_SLOTS-1:0]   io_slot_sel,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic [ROM_BANK_W-1:0] rom_bank
);

    region_t region;
    logic    sel_enable;

    // Reads decode at once; writes only during the high phase.
    assign sel_enable = rw || phi2;

    memdec_region #(
        .ADDR_W    (ADDR_W),
        .IO_BASE   (IO_BASE),
        .BRAM_BASE (BRAM_BASE),
        .ROM_BASE  (ROM_BASE)
    ) u_region (
        .addr   (addr),
        .region (region)
    );

    memdec_select #(
        .ADDR_W        (ADDR_W),
        .IO_SLOTS      (IO_SLOTS),
        .IO_SLOT_SHIFT (IO_SLOT_SHIFT)
    ) u_select (
        .region      (region),
        .addr        (addr),
        .enable      (sel_enable),
        .ram_cs      (ram_cs),
        .rom_cs      (rom_cs),
        .bram_cs     (bram_cs),
        .io_cs       (io_cs),
        .io_slot_sel (io_slot_sel)
    );

    memdec_bank_regs #(
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .RAM_BANK_W    (RAM_BANK_W),
        .ROM_BANK_W    (ROM_BANK_W),
        .RAM_BANK_ADDR (RAM_BANK_ADDR),
        .ROM_BANK_ADDR (ROM_BANK_ADDR)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .phi2     (phi2),
        .rw       (rw),
        .addr     (addr),
        .data_in  (data_in),
        .ram_bank (ram_bank),
        .rom_bank (rom_bank)
    );

endmodule

// File: rtl/memdec_sva.sv
module memdec_sva #(
    parameter int ADDR_W     = 16,
    parameter int RAM_BANK_W = 8,
    parameter int ROM_BANK_W = 5,
    parameter int IO_SLOTS   = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  phi2,
    input logic                  rw,
    input logic [ADDR_W-1:0]     addr,
    input logic                  ram_cs,
    input logic                  rom_cs,
    input logic                  bram_cs,
    input logic                  io_cs,
    input logic [IO_SLOTS-1:0]   io_slot_sel,
    input logic [RAM_BANK_W-1:0] ram_bank,
    input logic [ROM_BANK_W-1:0] rom_bank
);

    logic       phi2_q;
    logic [3:0] cs_vec;

    assign cs_vec = {ram_cs, rom_cs, bram_cs, io_cs};

    always_ff @(posedge clk) begin
        if (!rst_n) phi2_q <= 1'b0;
        else        phi2_q <= phi2;
    end

    AST_ONE_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (rw || phi2) |-> ($countones(cs_vec) == 1)); // R1

    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rw && !phi2) |-> (cs_vec == 4'b0 && io_slot_sel == '0)); // R1

    AST_ROM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rw && addr[ADDR_W-1:ADDR_W-2] == 2'b11) |-> rom_cs); // R2

    AST_ZP_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        ((rw || phi2) && addr[ADDR_W-1:1] == '0) |-> ram_cs); // R6

    AST_SLOT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        io_cs |-> ($countones(io_slot_sel) == 1)); // R3

    AST_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !io_cs |-> (io_slot_sel == '0)); // R3

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ram_bank == '0 && rom_bank == '0)); // R8

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(phi2_q && !phi2) |=> ($stable(ram_bank) && $stable(rom_bank))); // R9

endmodule

bind memdec_top memdec_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .phi2        (phi2),
    .rw          (rw),
    .addr        (addr),
    .ram_cs      (ram_cs),
    .rom_cs      (rom_cs),
    .bram_cs     (bram_cs),
    .io_cs       (io_cs),
    .io_slot_sel (io_slot_sel),
    .ram_bank    (ram_bank),
    .rom_bank    (rom_bank)
);

// File: tb/memdec_top_test.sv
module memdec_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  data_in = 8'h00;
    logic        rw = 1'b1;
    logic        ram_cs, rom_cs, bram_cs, io_cs;
    logic [7:0]  io_slot_sel;
    logic [7:0]  ram_bank;
    logic [4:0]  rom_bank;

    int checks = 0;
    int errors = 0;

    logic [7:0] zp_ram [0:255];
    logic [7:0] exp_ram_bank;
    logic [4:0] exp_rom_bank;
    logic [7:0] rd_val;

    always #2 clk = ~clk;

    memdec_top uut (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .addr(addr), .data_in(data_in),
        .rw(rw), .ram_cs(ram_cs), .rom_cs(rom_cs), .bram_cs(bram_cs),
        .io_cs(io_cs), .io_slot_sel(io_slot_sel), .ram_bank(ram_bank),
        .rom_bank(rom_bank)
    );

    // Expected {ram,rom,bram,io} from the address map in R2
    function automatic logic [3:0] exp_cs(input logic [15:0] a);
        if (a >= 16'hC000)      return 4'b0100;
        else if (a >= 16'hA000) return 4'b0010;
        else if (a >= 16'h9F00) return 4'b0001;
        else                    return 4'b1000;
    endfunction

    function automatic logic [7:0] exp_slot(input logic [15:0] a);
        if (exp_cs(a) == 4'b0001) return 8'(1) << a[7:5];
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_banks(input string req);
        check(req, {24'h0, ram_bank}, {24'h0, exp_ram_bank});
        check(req, {27'h0, rom_bank}, {27'h0, exp_rom_bank});
    endtask

    // One bus cycle: 2 clk low, 3 clk high, then a low-phase clk for the commit.
    task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic r);
        @(negedge clk);
        phi2 = 1'b0; addr = a; data_in = d; rw = r;
        @(negedge clk);
        if (!r) check("R1 low write gated", {27'h0, ram_cs, rom_cs, bram_cs, io_cs, |io_slot_sel}, 32'h0);
        else    check("R2 read decode", {28'h0, ram_cs, rom_cs, bram_cs, io_cs}, {28'h0, exp_cs(a)});
        @(negedge clk);
        phi2 = 1'b1;
        @(negedge clk);
        check("R2 decode high", {28'h0, ram_cs, rom_cs, bram_cs, io_cs}, {28'h0, exp_cs(a)});
        check("R3 slot", {24'h0, io_slot_sel}, {24'h0, exp_slot(a)});
        if (r && ram_cs && a < 16'h0100) rd_val = zp_ram[a[7:0]];
        if (!r && ram_cs && a < 16'h0100) zp_ram[a[7:0]] = d;
        @(negedge clk);
        @(negedge clk);
        phi2 = 1'b0;
        @(negedge clk);   // commit edge has passed
        if (!r && a == 16'h0000) exp_ram_bank = d;
        if (!r && a == 16'h0001) exp_rom_bank = d[4:0];
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] a;
        logic [7:0]  d;
        logic        r;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) zp_ram[i] = 8'hA5;
        exp_ram_bank = 8'h00;
        exp_rom_bank = 5'h00;
        rd_val = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_banks("R8 reset");

        // R4: write RAM bank, read back from RAM
        bus_cycle(16'h0000, 8'h5C, 1'b0);
        check_banks("R4 ram bank write");
        bus_cycle(16'h0000, 8'h00, 1'b1);
        check("R6 readback ram", {24'h0, rd_val}, {24'h0, ram_bank});
        check_banks("R6 read no change");

        // R5: only low 5 bits reach the ROM bank
        bus_cycle(16'h0001, 8'hF7, 1'b0);
        check_banks("R5 rom bank write");
        bus_cycle(16'h0001, 8'h00, 1'b1);
        check("R6 readback rom", {27'h0, rd_val[4:0]}, {27'h0, rom_bank});

        // R7: neighbours and other regions do not load
        bus_cycle(16'h0002, 8'h11, 1'b0);
        check_banks("R7 addr 2");
        bus_cycle(16'h9F00, 8'h22, 1'b0);
        check_banks("R7 io write");
        bus_cycle(16'hA000, 8'h33, 1'b0);
        bus_cycle(16'hC000, 8'h44, 1'b0);
        check_banks("R7 rom write");

        // R2/R3 boundaries
        bus_cycle(16'h9EFF, 8'h00, 1'b1);
        bus_cycle(16'h9FFF, 8'h00, 1'b1);
        bus_cycle(16'hBFFF, 8'h00, 1'b1);
        bus_cycle(16'hFFFF, 8'h00, 1'b1);
        bus_cycle(16'h9F60, 8'h00, 1'b1);

        // R8: reset mid-run clears
        @(negedge clk); rst_n = 1'b0;
        exp_ram_bank = 8'h00; exp_rom_bank = 5'h00;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check_banks("R8 reset again");

        // Random traffic biased toward zero page and the I/O page
        for (int i = 0; i < 400; i++) begin
            case ($urandom_range(0, 3))
                0: a = 16'($urandom_range(0, 3));
                1: a = 16'h9F00 | 16'($urandom_range(0, 255));
                default: a = 16'($urandom);
            endcase
            d = 8'($urandom);
            r = 1'($urandom);
            bus_cycle(a, d, r);
            check_banks(r ? "R7 random read" : "R4 R5 R7 random write");
            if (!r && a < 16'h0002) begin
                bus_cycle(a, 8'h00, 1'b1);
                if (a == 16'h0000)
                    check("R6 random readback", {24'h0, rd_val}, {24'h0, ram_bank});
                else
                    check("R6 random readback", {27'h0, rd_val[4:0]}, {27'h0, rom_bank});
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule